// File: doc/BRIEF.md
# Addressed Serial Attenuator Bus Master

This block is the host-side driver for a shared three-wire control bus with up to eight step attenuators on it. Each attenuator answers to its own 3-bit address. A client hands over a target address and a 6-bit attenuation code through a valid/ready handshake. The block packs them into a 16-bit word and shifts that word out one bit per bus clock, least significant bit first, while the latch strobe stays low. When the last bit has been clocked, it raises the latch strobe once, which tells the addressed attenuator to apply the new code.

Every bus interval is a whole number of system clocks, set by a parameter. These intervals are the bus-clock high and low phases, the gap between the last bus-clock fall and the strobe, and the strobe width. They are sized so that the attenuator's minimum period, setup, hold and pulse-width limits are met at the system clock in use. A one-cycle `done` pulse marks the end of each transfer. While a transfer is in progress, `req_ready` stays low, so a waiting request is held back and is never lost or merged with another.

Top module: `atten_bus_master`

## Requirements
- R1: Each transfer shifts exactly 16 bits. In transmission order, bit 0 (the first) is 0. Bits 1..6 carry code bits 0..5. Bit 7 is 0. Bits 8..10 carry address bits 0..2. Bits 11..15 are 0.
- R2: Out of reset and whenever idle, `bus_clk`, `bus_le`, `bus_si` and `done` are low and `req_ready` is high.
- R3: `bus_le` stays low across all 16 bus-clock pulses of a transfer. It rises exactly once per transfer, after the 16th bit, and is never high together with `bus_clk`.
- R4: Every bus-clock high phase and every low phase between two pulses lasts exactly `HALF_CYC` system cycles.
- R5: `bus_si` changes only while `bus_clk` is low, and it is stable for the whole of each high phase.
- R6: `bus_le` rises exactly `GAP_CYC` system cycles after the final bus-clock falling edge.
- R7: `bus_le` stays high for exactly `PULSE_CYC` system cycles. `done` is high for one cycle only: the cycle in which `bus_le` returns low.
- R8: `req_ready` goes low in the cycle after a request is accepted. It stays low until the cycle in which `bus_le` returns low, and it is high in that cycle.
- R9: A request presented while busy is held off. Requests are transmitted in the order they were accepted, one transfer per request, with none dropped.
- R10: The first bus-clock rising edge of a transfer comes `HALF_CYC` system cycles after the accepting clock edge, with bit 0 already on `bus_si`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 3 | Target attenuator address |
| req_code | input | 6 | Attenuation code, one LSB per step |
| bus_si | output | 1 | Serial data line |
| bus_clk | output | 1 | Serial bus clock |
| bus_le | output | 1 | Latch strobe |
| done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The bench builds the block with `HALF_CYC=1`, `GAP_CYC=2` and `PULSE_CYC=3`. A half period of 1 is the minimum legal value, and it is the setting most likely to expose an off-by-one in the phase timer. Because the three intervals all differ, a phase that ends on the wrong timer load shows up as a wrong length. Every one of the 512 address/code pairs is sent, mostly back to back so that each new request waits on `req_ready`. Each frame, phase length and handshake edge is compared against values the bench works out itself.

// File: rtl/atten_bus_pkg.sv
package atten_bus_pkg;

    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 3;
    localparam int CODE_W  = 6;

    // word layout, lowest field is shifted out first
    typedef struct packed {
        logic [FRAME_W-ADDR_W-CODE_W-3:0] addr_pad;
        logic [ADDR_W-1:0]                addr;
        logic                             spare_hi;
        logic [CODE_W-1:0]                code;
        logic                             spare_lo;
    } frame_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOW   = 3'd1,
        ST_HIGH  = 3'd2,
        ST_GAP   = 3'd3,
        ST_PULSE = 3'd4
    } bus_state_t;

    function automatic frame_t make_frame(input logic [ADDR_W-1:0] addr,
                                          input logic [CODE_W-1:0] code);
        frame_t f;
        f.addr_pad = '0;
        f.addr     = addr;
        f.spare_hi = 1'b0;
        f.code     = code;
        f.spare_lo = 1'b0;
        return f;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/atten_frame_fmt.sv
module atten_frame_fmt
    import atten_bus_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CODE_W-1:0]  code,
    output logic [FRAME_W-1:0] frame
);

    frame_t f;

    always_comb begin
        f     = make_frame(addr, code);
        frame = f;
    end

endmodule

// File: rtl/atten_interval_timer.sv
module atten_interval_timer #(
    parameter int LOAD_MAX = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic [((LOAD_MAX < 2) ? 1 : $clog2(LOAD_MAX + 1))-1:0] load_val,
    output logic expire
);

    localparam int CNT_W = (LOAD_MAX < 2) ? 1 : $clog2(LOAD_MAX + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);

    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(LOAD_MAX));

endmodule

// File: rtl/atten_shifter.sv
module atten_shifter
    import atten_bus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               shift,
    output logic               bit_out,
    output logic               last_bit
);

    localparam int IDX_W = $clog2(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [IDX_W-1:0]   idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            idx   <= '0;
        end else if (load) begin
            shreg <= frame;
            idx   <= '0;
        end else if (shift) begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
        end
    end

    assign bit_out  = shreg[0];
    assign last_bit = (idx == IDX_W'(FRAME_W - 1));

    p_no_shift_past_end_r1: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |-> !last_bit);

endmodule

// File: rtl/atten_bus_master.sv
module atten_bus_master
    import atten_bus_pkg::*;
#(
    parameter int HALF_CYC  = 1,
    parameter int GAP_CYC   = 2,
    parameter int PULSE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CODE_W-1:0] req_code,
    output logic              bus_si,
    output logic              bus_clk,
    output logic              bus_le,
    output logic              done
);

    localparam int LOAD_MAX = max3(HALF_CYC, GAP_CYC, PULSE_CYC) - 1;
    localparam int CNT_W    = (LOAD_MAX < 2) ? 1 : $clog2(LOAD_MAX + 1);
    localparam logic [CNT_W-1:0] LD_HALF  = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);

    bus_state_t         st, st_nx;
    logic               tmr_load, tmr_exp;
    logic [CNT_W-1:0]   tmr_val;
    logic               sh_load, sh_shift, sh_bit, sh_last;
    logic [FRAME_W-1:0] frame;
    logic               accept;
    logic               done_q;

    atten_frame_fmt u_fmt (
        .addr  (req_addr),
        .code  (req_code),
        .frame (frame)
    );

    atten_interval_timer #(.LOAD_MAX(LOAD_MAX)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_exp)
    );

    atten_shifter u_sh (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .frame    (frame),
        .shift    (sh_shift),
        .bit_out  (sh_bit),
        .last_bit (sh_last)
    );

    assign accept = req_valid && (st == ST_IDLE);

    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (st)
            ST_IDLE: if (accept) begin
                st_nx    = ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = LD_HALF;
                sh_load  = 1'b1;
            end
            ST_LOW: if (tmr_exp) begin
                st_nx    = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = LD_HALF;
            end
            ST_HIGH: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (sh_last) begin
                    st_nx   = ST_GAP;
                    tmr_val = LD_GAP;
                end else begin
                    st_nx    = ST_LOW;
                    tmr_val  = LD_HALF;
                    sh_shift = 1'b1;
                end
            end
            ST_GAP: if (tmr_exp) begin
                st_nx    = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = LD_PULSE;
            end
            ST_PULSE: if (tmr_exp) begin
                st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            done_q <= 1'b0;
        end else begin
            st     <= st_nx;
            done_q <= (st == ST_PULSE) && tmr_exp;
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign bus_clk   = (st == ST_HIGH);
    assign bus_le    = (st == ST_PULSE);
    assign bus_si    = ((st == ST_LOW) || (st == ST_HIGH)) ? sh_bit : 1'b0;
    assign done      = done_q;

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_clk && !bus_le && !bus_si));

    p_le_excludes_clk_r3: assert property (@(posedge clk) disable iff (rst)
        bus_le |-> !bus_clk);

    p_si_held_high_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_clk && $past(bus_clk)) |-> $stable(bus_si));

    p_done_on_le_fall_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(bus_le));

    p_ready_drops_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_returns_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_le) |-> req_ready);

endmodule

// File: tb/atten_bus_master_bench.sv
module atten_bus_master_bench;

    localparam int HALF  = 1;
    localparam int GAP   = 2;
    localparam int PULSE = 3;
    localparam int NREQ  = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_addr = '0;
    logic [5:0] req_code = '0;
    logic       bus_si, bus_clk, bus_le, done;

    always #2.5 clk = ~clk;

    atten_bus_master #(.HALF_CYC(HALF), .GAP_CYC(GAP), .PULSE_CYC(PULSE)) u_atten_bus_master (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_code  (req_code),
        .bus_si    (bus_si),
        .bus_clk   (bus_clk),
        .bus_le    (bus_le),
        .done      (done)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    logic [15:0] exp_frame [NREQ];
    int          n_issued = 0;

    // monitor state
    bit          mon_on = 1'b0;
    logic        p_clk = 1'b0, p_le = 1'b0, p_si = 1'b0, p_ready = 1'b1;
    logic [15:0] cap;
    int          nbits = 0, hi_run = 0, lo_run = 0, le_run = 0, frame_no = 0;
    bit          in_frame = 1'b0, first_rise = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            // start of a transfer
            if (p_ready && !req_ready) begin
                in_frame   = 1'b1;
                first_rise = 1'b1;
                nbits      = 0;
                lo_run     = 1;
                cap        = '0;
                chk(!bus_clk && !bus_le, "R10 clk low at start", int'(bus_clk), 0);
            end else if (bus_clk && !p_clk) begin
                chk(!bus_le, "R3 le low during clock", int'(bus_le), 0);
                chk(lo_run == HALF, first_rise ? "R10 first low phase" : "R4 low phase",
                    lo_run, HALF);
                first_rise = 1'b0;
                if (nbits < 16) cap[nbits] = bus_si;
                nbits++;
                hi_run = 1;
            end else if (!bus_clk && p_clk) begin
                chk(hi_run == HALF, "R4 high phase", hi_run, HALF);
                lo_run = 1;
            end else if (bus_clk) begin
                hi_run++;
            end else if (in_frame && !bus_le && !p_le) begin
                lo_run++;
            end

            if (bus_le && !p_le) begin
                chk(in_frame, "R3 le only inside a transfer", int'(in_frame), 1);
                chk(lo_run == GAP, "R6 gap before le", lo_run, GAP);
                chk(nbits == 16, "R3 bit count before le", nbits, 16);
                if (frame_no < n_issued)
                    chk(cap == exp_frame[frame_no], "R1 frame content", int'(cap),
                        int'(exp_frame[frame_no]));
                else
                    chk(1'b0, "R9 unexpected frame", frame_no, n_issued);
                le_run = 1;
            end else if (bus_le && p_le) begin
                le_run++;
            end

            if (!bus_le && p_le) begin
                chk(le_run == PULSE, "R7 le width", le_run, PULSE);
                chk(done, "R7 done at le fall", int'(done), 1);
                chk(req_ready, "R8 ready at le fall", int'(req_ready), 1);
                in_frame = 1'b0;
                frame_no++;
            end else begin
                if (done) chk(1'b0, "R7 stray done", 1, 0);
                if (in_frame && req_ready) chk(1'b0, "R8 ready while busy", 1, 0);
            end

            if (bus_si != p_si && bus_clk) chk(1'b0, "R5 si moved with clk high", 1, 0);
            if (req_ready && !bus_le && !(in_frame))
                if (bus_si || bus_clk) chk(1'b0, "R2 idle bus not quiet",
                                           int'({bus_si, bus_clk}), 0);
        end
        p_clk   = bus_clk;
        p_le    = bus_le;
        p_si    = bus_si;
        p_ready = req_ready;
    end

    bit timed_out = 1'b0;

    task automatic drive_all();
        for (int a = 0; a < 8; a++) begin
            for (int c = 0; c < 64; c++) begin
                if (c % 16 == 5) repeat (3) @(negedge clk);
                req_addr  = 3'(a);
                req_code  = 6'(c);
                req_valid = 1'b1;
                exp_frame[n_issued] = {5'b0, 3'(a), 1'b0, 6'(c), 1'b0};
                n_issued++;
                while (!req_ready) @(negedge clk);
                @(negedge clk);
                req_valid = 1'b0;
            end
        end
        while (!req_ready || in_frame) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk(req_ready, "R2 ready after reset", int'(req_ready), 1);
        chk(!bus_clk && !bus_le && !bus_si, "R2 bus idle after reset",
            int'({bus_clk, bus_le, bus_si}), 0);
        chk(!done, "R2 done low after reset", int'(done), 0);
        p_ready = req_ready;
        mon_on  = 1'b1;
        fork
            drive_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        chk(!timed_out, "R9 watchdog expired", int'(timed_out), 0);
        chk(frame_no == NREQ, "R9 frames delivered", frame_no, NREQ);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule